// File: doc/BRIEF.md
# Clock Generator Power-Down and Lock-Wait Sequencer

This block is the control sequencer for a multi-output clock generator. It runs from a free-running low-speed timing clock. It watches an asynchronous active-low power-down input and a small set of mode-select pins, and from them it drives four kinds of output:

- the enable for the reference oscillator;
- the enables for the frequency synthesizers;
- a per-output clock gate and pad-driver enable;
- a single clock-ready flag.

A power-down request stops everything at once. When power-down is released, the block times a settling window before it lets the outputs toggle. That window is the oscillator settling time followed by the synthesizer lock time when the on-chip crystal oscillator is in use, and the lock time alone when an external clock drives the reference.

A change on the mode pins reselects the synthesizer settings. Because the synthesizers must then relock, such a change withdraws the clock-ready flag and the output gates until a fresh lock interval has run. Both the power-down pin and the mode pins are resynchronised to the timing clock and filtered, so that short glitches have no effect. The settling and lock intervals are parameters counted in timing-clock ticks. The stop-state style of the pads (driven low, or high impedance) and the set of outputs in use are also parameters.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: While reset is high, osc_en, pll_en, out_gate and clk_ready are all 0 and mode_active is 0.
- R2: pwrdn_n passes through a two-stage synchroniser. A power-down is recognised only after the synchronised level has been low on PD_MIN_TICKS consecutive ticks. A low pulse of PD_MIN_TICKS-1 ticks changes no output.
- R3: Once a power-down is recognised, from any state, the next tick drives osc_en, every pll_en bit, every out_gate bit and clk_ready to 0. With STOP_HIZ=1, every out_drv bit also goes to 0. With pwrdn_n driven low PD_MIN_TICKS ticks into the run state, clk_ready is first seen low after the (3+PD_MIN_TICKS)-th rising edge.
- R4: With int_osc_sel=1, releasing pwrdn_n from a recognised power-down gives three windows: osc_en rises after the 4th rising edge; pll_en rises OSC_TICKS edges after that; clk_ready rises after edge 4+OSC_TICKS+LOCK_TICKS. The synthesizers are never enabled while the oscillator is off.
- R5: With int_osc_sel=0, osc_en and all pll_en bits rise together after the 4th rising edge following release, and clk_ready rises after edge 4+LOCK_TICKS.
- R6: The mode pins pass through a two-stage synchroniser and a debounce. A new value is taken into mode_active only after it has been held for DB_TICKS+1 ticks; mode_active then changes after rising edge 3+DB_TICKS. A value held for DB_TICKS ticks or fewer is ignored.
- R7: An accepted mode change in the run state or in the lock wait has three effects. clk_ready falls after rising edge 4+DB_TICKS. The lock timer restarts from zero, so clk_ready returns after edge 4+DB_TICKS+LOCK_TICKS, counted from the last change. osc_en stays 1 throughout.
- R8: An accepted mode change during the oscillator-settling window or during power-down leaves the release-to-ready timing of R4 unchanged.
- R9: In the run state, clk_ready is 1 and out_gate equals OUT_USED. An output whose OUT_USED bit is 0 never has its gate set; with the bench mask 8'hF7, bit 3 stays 0.
- R10: All pll_en bits are 1 in the lock wait and in the run state, and all are 0 otherwise. clk_ready is never 1 unless every pll_en bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running low-speed timing clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| int_osc_sel | input | 1 | 1: on-chip crystal oscillator needs a settling wait; 0: external reference clock |
| sel_pins | input | MODE_W | Asynchronous mode-select pins |
| osc_en | output | 1 | Reference oscillator enable |
| pll_en | output | N_PLL | Synthesizer enables |
| out_gate | output | N_OUT | Per-output clock gate, 1 lets the clock toggle |
| out_drv | output | N_OUT | Per-output pad-driver enable, 0 places the pad in high impedance |
| clk_ready | output | 1 | Output clocks are settled and valid |
| mode_active | output | MODE_W | Debounced mode currently applied to the synthesizers |

## Verification
Power-down release is tried twice: once with the internal-oscillator selection and once with the external-reference selection. The measured edge counts for osc_en, pll_en and clk_ready separate the two-window sequence from the lock-only one.

Power-down pulses one tick shorter than the filter width and exactly at the filter width test the glitch filter at its boundary. Mode-pin glitches one tick short of acceptance do the same for the debounce.

Further mode changes are made in three places:
- in the run state;
- twice within one lock wait, where a restarted timer is told apart from a continued one by the ready time;
- inside the oscillator-settling window, which must not disturb it.

A power-down raised in the middle of the lock wait checks that every wait state gives way to power-down.

// File: rtl/clkgen_pwr_pkg.sv
package clkgen_pwr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_OSC  = 2'd1,
        ST_LOCK = 2'd2,
        ST_RUN  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic osc;
        logic pll;
        logic gate;
        logic ready;
    } pwr_ctl_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pwr_ctl_t ctl_of(input pwr_state_e s);
        pwr_ctl_t c;
        c.osc   = (s != ST_OFF);
        c.pll   = (s == ST_LOCK) || (s == ST_RUN);
        c.gate  = (s == ST_RUN);
        c.ready = (s == ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/clkgen_pwr_pdfilt.sv
module clkgen_pwr_pdfilt #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_n,
    output logic pd_sync,
    output logic pd_req
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [SYNC_STAGES-1:0] sh;
    logic [CW-1:0]          low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '1;
            low_run <= '0;
        end else begin
            sh <= {sh[SYNC_STAGES-2:0], pwrdn_n};
            if (sh[SYNC_STAGES-1]) begin
                low_run <= '0;
            end else if (low_run != CW'(MIN_LOW)) begin
                low_run <= low_run + 1'b1;
            end
        end
    end

    assign pd_sync = sh[SYNC_STAGES-1];
    assign pd_req  = (low_run == CW'(MIN_LOW));

endmodule

// File: rtl/clkgen_pwr_modedb.sv
module clkgen_pwr_modedb #(
    parameter int W           = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DB_TICKS    = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sel_pins,
    output logic [W-1:0] mode_cur,
    output logic         mode_chg
);
    localparam int DBW = $clog2(DB_TICKS + 1);

    logic [W-1:0]   stg [SYNC_STAGES];
    logic [W-1:0]   cand;
    logic [DBW-1:0] db_cnt;
    logic [W-1:0]   smp;

    assign smp = stg[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            cand     <= '0;
            mode_cur <= '0;
            db_cnt   <= '0;
            mode_chg <= 1'b0;
        end else begin
            stg[0] <= sel_pins;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            mode_chg <= 1'b0;
            if (smp != cand) begin
                cand   <= smp;
                db_cnt <= '0;
            end else if (cand != mode_cur) begin
                if (db_cnt == DBW'(DB_TICKS - 1)) begin
                    mode_cur <= cand;
                    db_cnt   <= '0;
                    mode_chg <= 1'b1;
                end else begin
                    db_cnt <= db_cnt + 1'b1;
                end
            end else begin
                db_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/clkgen_pwr_fsm.sv
module clkgen_pwr_fsm
    import clkgen_pwr_pkg::*;
#(
    parameter int OSC_TICKS  = 200,
    parameter int LOCK_TICKS = 330
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_req,
    input  logic       mode_chg,
    input  logic       int_osc_sel,
    output pwr_state_e state
);
    localparam int TMR_W = $clog2(imax(OSC_TICKS, LOCK_TICKS) + 1);

    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            tmr   <= '0;
        end else if (pd_req) begin
            state <= ST_OFF;
            tmr   <= '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    tmr   <= '0;
                    state <= int_osc_sel ? ST_OSC : ST_LOCK;
                end
                ST_OSC: begin
                    if (tmr == TMR_W'(OSC_TICKS - 1)) begin
                        state <= ST_LOCK;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (mode_chg) begin
                        tmr <= '0;
                    end else if (tmr == TMR_W'(LOCK_TICKS - 1)) begin
                        state <= ST_RUN;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (mode_chg) begin
                        state <= ST_LOCK;
                        tmr   <= '0;
                    end
                end
                default: begin
                    state <= ST_OFF;
                    tmr   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/clkgen_pwr_seq.sv
module clkgen_pwr_seq
    import clkgen_pwr_pkg::*;
#(
    parameter int               N_OUT        = 8,
    parameter int               N_PLL        = 4,
    parameter int               MODE_W       = 2,
    parameter int               SYNC_STAGES  = 2,
    parameter int               PD_MIN_TICKS = 2,
    parameter int               DB_TICKS     = 3,
    parameter int               OSC_TICKS    = 200,
    parameter int               LOCK_TICKS   = 330,
    parameter bit               STOP_HIZ     = 1'b0,
    parameter logic [N_OUT-1:0] OUT_USED     = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwrdn_n,
    input  logic              int_osc_sel,
    input  logic [MODE_W-1:0] sel_pins,
    output logic              osc_en,
    output logic [N_PLL-1:0]  pll_en,
    output logic [N_OUT-1:0]  out_gate,
    output logic [N_OUT-1:0]  out_drv,
    output logic              clk_ready,
    output logic [MODE_W-1:0] mode_active
);
    logic       pd_sync;
    logic       pd_req;
    logic       mode_chg;
    pwr_state_e state;
    pwr_ctl_t   ctl;

    clkgen_pwr_pdfilt #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_LOW    (PD_MIN_TICKS)
    ) u_pdfilt (
        .clk    (clk),
        .rst    (rst),
        .pwrdn_n(pwrdn_n),
        .pd_sync(pd_sync),
        .pd_req (pd_req)
    );

    clkgen_pwr_modedb #(
        .W          (MODE_W),
        .SYNC_STAGES(SYNC_STAGES),
        .DB_TICKS   (DB_TICKS)
    ) u_modedb (
        .clk     (clk),
        .rst     (rst),
        .sel_pins(sel_pins),
        .mode_cur(mode_active),
        .mode_chg(mode_chg)
    );

    clkgen_pwr_fsm #(
        .OSC_TICKS (OSC_TICKS),
        .LOCK_TICKS(LOCK_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pd_req     (pd_req),
        .mode_chg   (mode_chg),
        .int_osc_sel(int_osc_sel),
        .state      (state)
    );

    assign ctl       = ctl_of(state);
    assign osc_en    = ctl.osc;
    assign pll_en    = {N_PLL{ctl.pll}};
    assign clk_ready = ctl.ready;

    for (genvar g = 0; g < N_OUT; g++) begin : gen_out
        assign out_gate[g] = ctl.gate & OUT_USED[g];
        if (STOP_HIZ) begin : gen_hiz
            assign out_drv[g] = out_gate[g];
        end else begin : gen_low
            assign out_drv[g] = 1'b1;
        end
    end

endmodule

// File: rtl/clkgen_pwr_seq_chk.sv
module clkgen_pwr_seq_chk #(
    parameter int               N_OUT    = 8,
    parameter int               N_PLL    = 4,
    parameter logic [N_OUT-1:0] OUT_USED = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             pd_sync,
    input logic             pd_req,
    input logic             mode_chg,
    input logic             osc_en,
    input logic [N_PLL-1:0] pll_en,
    input logic [N_OUT-1:0] out_gate,
    input logic             clk_ready
);
    AST_PD_FILTER: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_req) |-> !pd_sync);                                   // R2

    AST_PD_STOP: assert property (@(posedge clk) disable iff (rst)
        pd_req |=> (!osc_en && pll_en == '0 && out_gate == '0 && !clk_ready)); // R3

    AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        (|pll_en) |-> osc_en);                                         // R4

    AST_READY_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_ready) |-> $past(&pll_en));                          // R4

    AST_MODE_DROP: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && clk_ready && !pd_req) |=> (!clk_ready && osc_en)); // R7

    AST_UNUSED_OFF: assert property (@(posedge clk) disable iff (rst)
        (out_gate & ~OUT_USED) == '0);                                 // R9

    AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
        clk_ready |-> (&pll_en && out_gate == OUT_USED));              // R10

endmodule

bind clkgen_pwr_seq clkgen_pwr_seq_chk #(
    .N_OUT   (N_OUT),
    .N_PLL   (N_PLL),
    .OUT_USED(OUT_USED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pd_sync  (pd_sync),
    .pd_req   (pd_req),
    .mode_chg (mode_chg),
    .osc_en   (osc_en),
    .pll_en   (pll_en),
    .out_gate (out_gate),
    .clk_ready(clk_ready)
);

// File: tb/clkgen_pwr_seq_test.sv
module clkgen_pwr_seq_test;
    localparam int         N_OUT  = 8;
    localparam int         N_PLL  = 4;
    localparam int         MODE_W = 2;
    localparam int         PD_MIN = 4;
    localparam int         DB     = 3;
    localparam int         OSC    = 12;
    localparam int         LOCK   = 20;
    localparam logic [7:0] USED   = 8'hF7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pwrdn_n = 1'b1;
    logic              int_osc_sel = 1'b1;
    logic [MODE_W-1:0] sel_pins = '0;
    logic              osc_en;
    logic [N_PLL-1:0]  pll_en;
    logic [N_OUT-1:0]  out_gate;
    logic [N_OUT-1:0]  out_drv;
    logic              clk_ready;
    logic [MODE_W-1:0] mode_active;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  mdl_on = 1'b0;

    always #4 clk = ~clk;

    clkgen_pwr_seq #(
        .N_OUT(N_OUT), .N_PLL(N_PLL), .MODE_W(MODE_W), .SYNC_STAGES(2),
        .PD_MIN_TICKS(PD_MIN), .DB_TICKS(DB), .OSC_TICKS(OSC),
        .LOCK_TICKS(LOCK), .STOP_HIZ(1'b1), .OUT_USED(USED)
    ) uut (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .int_osc_sel(int_osc_sel),
        .sel_pins(sel_pins), .osc_en(osc_en), .pll_en(pll_en),
        .out_gate(out_gate), .out_drv(out_drv), .clk_ready(clk_ready),
        .mode_active(mode_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phases 0 off, 1 oscillator settle, 2 lock, 3 run
    int m_s1, m_s2, m_low, m_phase, m_left;
    int m_q1, m_q2, m_prev, m_hold, m_cur, m_chg;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_low = 0; m_phase = 0; m_left = 0;
            m_q1 = 0; m_q2 = 0; m_prev = 0; m_hold = 0; m_cur = 0; m_chg = 0;
        end else begin
            if (m_low >= PD_MIN) begin
                m_phase = 0;
            end else if (m_phase == 0) begin
                m_phase = int_osc_sel ? 1 : 2;
                m_left  = int_osc_sel ? OSC : LOCK;
            end else if (m_phase == 1) begin
                m_left--;
                if (m_left == 0) begin m_phase = 2; m_left = LOCK; end
            end else if (m_phase == 2) begin
                if (m_chg != 0) m_left = LOCK;
                else begin
                    m_left--;
                    if (m_left == 0) m_phase = 3;
                end
            end else if (m_chg != 0) begin
                m_phase = 2; m_left = LOCK;
            end
            if (m_s2 != 0) m_low = 0; else if (m_low < PD_MIN) m_low++;
            m_s2 = m_s1; m_s1 = int'(pwrdn_n);
            m_chg = 0;
            if (m_q2 == m_prev) begin if (m_hold < DB + 1) m_hold++; end
            else m_hold = 1;
            m_prev = m_q2;
            if (m_hold >= DB + 1 && m_q2 != m_cur) begin m_cur = m_q2; m_chg = 1; end
            m_q2 = m_q1; m_q1 = int'(sel_pins);
        end
    end

    always @(negedge clk) begin
        if (mdl_on && !rst && !done) begin
            chk("R3 model out_drv", int'(out_drv), (m_phase == 3) ? int'(USED) : 0);
            chk("R4 model osc_en", int'(osc_en), (m_phase != 0) ? 1 : 0);
            chk("R6 model mode_active", int'(mode_active), m_cur);
            chk("R9 model out_gate", int'(out_gate), (m_phase == 3) ? int'(USED) : 0);
            chk("R9 model clk_ready", int'(clk_ready), (m_phase == 3) ? 1 : 0);
            chk("R10 model pll_en", int'(pll_en), (m_phase >= 2) ? 15 : 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_pd();
        pwrdn_n = 1'b0;
        repeat (PD_MIN + 6) tick();
    endtask

    task automatic release_pd(input int mode_at, input int mode_val,
                              output int t_osc, output int t_pll, output int t_rdy);
        t_osc = -1; t_pll = -1; t_rdy = -1;
        pwrdn_n = 1'b1;
        for (int n = 1; n <= 200; n++) begin
            tick();
            if (n == mode_at) sel_pins = MODE_W'(mode_val);
            if (t_osc < 0 && osc_en) t_osc = n;
            if (t_pll < 0 && pll_en == '1) t_pll = n;
            if (clk_ready) begin t_rdy = n; break; end
        end
    endtask

    task automatic mode_step(input int val, output int t_mode, output int t_drop,
                             output int t_rdy, output int osc_low);
        t_mode = -1; t_drop = -1; t_rdy = -1; osc_low = 0;
        sel_pins = MODE_W'(val);
        for (int n = 1; n <= 200; n++) begin
            tick();
            if (!osc_en) osc_low = 1;
            if (t_mode < 0 && int'(mode_active) == val) t_mode = n;
            if (t_drop < 0 && !clk_ready) t_drop = n;
            if (t_drop > 0 && clk_ready) begin t_rdy = n; break; end
        end
    endtask

    initial begin
        int a, b, c, d;
        int stayed;
        repeat (3) tick();
        chk("R1 reset osc_en", int'(osc_en), 0);
        chk("R1 reset pll_en", int'(pll_en), 0);
        chk("R1 reset out_gate", int'(out_gate), 0);
        chk("R1 reset clk_ready", int'(clk_ready), 0);
        chk("R1 reset mode_active", int'(mode_active), 0);
        rst = 1'b0;
        mdl_on = 1'b1;

        // Internal oscillator release
        enter_pd();
        chk("R3 pd osc_en", int'(osc_en), 0);
        chk("R3 pd out_drv hiz", int'(out_drv), 0);
        release_pd(-1, 0, a, b, c);
        chk("R4 osc_en rise edge", a, 4);
        chk("R4 pll_en rise edge", b, 4 + OSC);
        chk("R4 ready edge", c, 4 + OSC + LOCK);
        chk("R9 gates in run", int'(out_gate), int'(USED));
        chk("R10 pll all on in run", int'(pll_en), 15);

        // External reference release
        int_osc_sel = 1'b0;
        enter_pd();
        release_pd(-1, 0, a, b, c);
        chk("R5 osc_en rise edge", a, 4);
        chk("R5 pll_en rise edge", b, 4);
        chk("R5 ready edge", c, 4 + LOCK);
        int_osc_sel = 1'b1;

        // Power-down filter boundary
        pwrdn_n = 1'b0;
        repeat (PD_MIN - 1) tick();
        pwrdn_n = 1'b1;
        stayed = 1;
        repeat (12) begin tick(); if (!clk_ready || !osc_en) stayed = 0; end
        chk("R2 short pulse ignored", stayed, 1);
        pwrdn_n = 1'b0;
        a = -1;
        for (int n = 1; n <= 40; n++) begin
            tick();
            if (!clk_ready) begin a = n; break; end
        end
        chk("R3 pd recognised edge", a, 3 + PD_MIN);
        chk("R3 pll_en off", int'(pll_en), 0);
        repeat (4) tick();
        release_pd(-1, 0, a, b, c);
        chk("R4 ready after filter test", c, 4 + OSC + LOCK);

        // Mode change in run
        mode_step(2, a, b, c, d);
        chk("R6 mode accept edge", a, 3 + DB);
        chk("R7 ready drop edge", b, 4 + DB);
        chk("R7 ready return edge", c, 4 + DB + LOCK);
        chk("R7 osc stays on", d, 0);

        // Mode glitch one tick short of acceptance
        sel_pins = 2'd1;
        repeat (DB) tick();
        sel_pins = 2'd2;
        stayed = 1;
        repeat (15) begin tick(); if (!clk_ready || mode_active != 2'd2) stayed = 0; end
        chk("R6 short mode glitch ignored", stayed, 1);

        // Second change inside lock wait restarts the timer
        sel_pins = 2'd3;
        for (int n = 1; n <= 40; n++) begin tick(); if (!clk_ready) break; end
        repeat (8) tick();
        mode_step(1, a, b, c, d);
        chk("R7 restart mode edge", a, 3 + DB);
        chk("R7 restart ready edge", c, 4 + DB + LOCK);

        // Mode change inside oscillator settle window
        enter_pd();
        release_pd(2, 0, a, b, c);
        chk("R8 ready edge with mode change", c, 4 + OSC + LOCK);
        chk("R8 mode applied", int'(mode_active), 0);

        // Power-down during lock wait
        enter_pd();
        pwrdn_n = 1'b1;
        repeat (4 + OSC + 4) tick();
        chk("R10 pll on in lock wait", int'(pll_en), 15);
        chk("R9 ready low in lock wait", int'(clk_ready), 0);
        pwrdn_n = 1'b0;
        repeat (PD_MIN + 4) tick();
        chk("R3 pd from lock osc_en", int'(osc_en), 0);
        chk("R3 pd from lock pll_en", int'(pll_en), 0);
        release_pd(-1, 0, a, b, c);
        chk("R4 ready after lock abort", c, 4 + OSC + LOCK);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule